// File: doc/BRIEF.md
# Watermark DMA Request Generator

This block watches how full a data buffer is and drives a request line towards an external DMA engine. In the write direction it asks for data whenever the free room in the buffer can take at least a programmed number of words. In the read direction it asks for service whenever at least a programmed number of words are waiting. The request is paced per data-port access. Any access pulls the request low at once. The request can come back two cycles after the access, if the threshold still holds.

Each direction also has a sticky ready flag. The flag is set whenever a request is raised in that direction while its status enable is on. Software clears it with a write-one-to-clear pulse. The generator is active only when external requests are enabled and the internal DMA engine is off. The buffer, the bus interface and interrupt merging live outside the block.

Top module: `wm_dma_req`

## Requirements
- R1: The block is active only while `ext_req_en` is 1 and `int_dma_on` is 0. While it is inactive, `dma_req` is 0 from the next cycle on.
- R2: With `dir_rd` = 0 (write), the request condition is free space ≥ effective write watermark. Free space is `capacity - level`, or 0 when `level` exceeds `capacity`.
- R3: With `dir_rd` = 1 (read), the request condition is `level` ≥ effective read watermark.
- R4: A watermark of 0 acts as 1. A watermark above `DEPTH` acts as `DEPTH`.
- R5: The request is registered. When the condition holds at a clock edge, `dma_req` is 1 after that edge. When it fails at an edge, `dma_req` is 0 after that edge.
- R6: In any cycle where `port_acc` is 1, `dma_req` is 0 in that same cycle.
- R7: The cycle that follows an access also has `dma_req` at 0. After that, the request returns if the condition still holds.
- R8: A change of `dir_rd` drives `dma_req` to 0 for the cycle after the edge that sees the change. The request can reassert one cycle later.
- R9: `wr_rdy` is set on the edge after a cycle with `dma_req` = 1, `dir_rd` = 0 and `wr_stat_en` = 1. Once set, it stays set until it is cleared.
- R10: `rd_rdy` is set on the edge after a cycle with `dma_req` = 1, `dir_rd` = 1 and `rd_stat_en` = 1. Once set, it stays set until it is cleared.
- R11: A 1 on `wr_rdy_clr` or `rd_rdy_clr` clears its flag at the next edge. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_en | input | 1 | External DMA request enable |
| int_dma_on | input | 1 | Internal DMA engine in use |
| dir_rd | input | 1 | Transfer direction: 1 = read, 0 = write |
| level | input | CNT_W | Words currently held in the buffer |
| capacity | input | CNT_W | Buffer capacity in words |
| wr_wm | input | CNT_W | Write watermark in words |
| rd_wm | input | CNT_W | Read watermark in words |
| wr_stat_en | input | 1 | Enable for setting the write-ready flag |
| rd_stat_en | input | 1 | Enable for setting the read-ready flag |
| port_acc | input | 1 | Data-port access strobe |
| wr_rdy_clr | input | 1 | Write-one-to-clear for `wr_rdy` |
| rd_rdy_clr | input | 1 | Write-one-to-clear for `rd_rdy` |
| dma_req | output | 1 | Request to the external DMA engine |
| wr_rdy | output | 1 | Sticky write-ready flag |
| rd_rdy | output | 1 | Sticky read-ready flag |

## Verification
Inputs change on the falling edge. A level or enable change shows on `dma_req` after one rising edge, because one register sits on that path. A direction change needs two edges before the request can return. The drop caused by an access is combinational, so the bench checks it shortly after driving `port_acc`, with no edge in between. It then checks the low cycle that follows the access and the recovery one edge later. The ready flags sit one register behind `dma_req`, so each flag check comes one edge after the request was seen high.

// File: rtl/wm_dma_pkg.sv
package wm_dma_pkg;

   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } xfer_dir_e;

   localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/wm_thresh_cmp.sv
module wm_thresh_cmp #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             dir_rd,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] capacity,
   input  logic [CNT_W-1:0] wr_wm,
   input  logic [CNT_W-1:0] rd_wm,
   output logic             hit
);
   import wm_dma_pkg::*;

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [CNT_W-1:0] wm_raw [NUM_DIRS];
   logic [CNT_W-1:0] wm_eff [NUM_DIRS];
   logic [CNT_W-1:0] free_words;

   assign wm_raw[0] = wr_wm;
   assign wm_raw[1] = rd_wm;

   // R4: the same clamp is built once per direction
   for (genvar d = 0; d < NUM_DIRS; d++) begin : g_clamp
      always_comb begin
         if (wm_raw[d] == '0) begin
            wm_eff[d] = ONE_C;
         end else if (wm_raw[d] > DEPTH_C) begin
            wm_eff[d] = DEPTH_C;
         end else begin
            wm_eff[d] = wm_raw[d];
         end
      end
   end

   // R2: free room, saturated at zero
   always_comb begin
      if (capacity > level) begin
         free_words = capacity - level;
      end else begin
         free_words = '0;
      end
   end

   always_comb begin
      if (dir_rd == DIR_RD) begin
         hit = (level >= wm_eff[1]);
      end else begin
         hit = (free_words >= wm_eff[0]);
      end
   end

endmodule

// File: rtl/wm_req_pacer.sv
module wm_req_pacer (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic hit,
   input  logic dir_rd,
   input  logic port_acc,
   output logic dma_req
);

   logic req_q;
   logic dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         dir_q <= dir_rd;
         req_q <= active & hit & ~port_acc & (dir_rd == dir_q);
      end
   end

   assign dma_req = req_q & ~port_acc;

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !dma_req);

   assert_gap_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_acc |=> !dma_req);

   assert_dir_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_rd != dir_q) |=> !dma_req);

   assert_registered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && hit && !port_acc && dir_rd == dir_q) |=> (dma_req || port_acc));

   always_comb begin
      assert_drop_on_access_R6: assert (!(port_acc && dma_req));
   end

endmodule

// File: rtl/wm_stat_flag.sv
module wm_stat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic req_seen,
   input  logic stat_en,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   // R11: a set in the same cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (req_seen && stat_en) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

   assert_set_cause_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(req_seen && stat_en));

   assert_sticky_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(req_seen && stat_en)) |=> !flag_q);

endmodule

// File: rtl/wm_dma_req.sv
module wm_dma_req #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_req_en,
   input  logic             int_dma_on,
   input  logic             dir_rd,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] capacity,
   input  logic [CNT_W-1:0] wr_wm,
   input  logic [CNT_W-1:0] rd_wm,
   input  logic             wr_stat_en,
   input  logic             rd_stat_en,
   input  logic             port_acc,
   input  logic             wr_rdy_clr,
   input  logic             rd_rdy_clr,
   output logic             dma_req,
   output logic             wr_rdy,
   output logic             rd_rdy
);
   import wm_dma_pkg::*;

   initial begin : p_param_chk
      assert_depth_min: assert (DEPTH >= 2)
         else $error("DEPTH must be at least 2");
      assert_cnt_width: assert ((1 << CNT_W) > DEPTH)
         else $error("CNT_W too narrow for DEPTH");
   end

   logic active;
   logic hit;
   logic req_w;
   logic flag_en  [NUM_DIRS];
   logic flag_clr [NUM_DIRS];
   logic flag_out [NUM_DIRS];

   // R1
   assign active = ext_req_en & ~int_dma_on;

   wm_thresh_cmp #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) u_cmp (
      .dir_rd   (dir_rd),
      .level    (level),
      .capacity (capacity),
      .wr_wm    (wr_wm),
      .rd_wm    (rd_wm),
      .hit      (hit)
   );

   wm_req_pacer u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .hit      (hit),
      .dir_rd   (dir_rd),
      .port_acc (port_acc),
      .dma_req  (req_w)
   );

   assign flag_en[0]  = wr_stat_en;
   assign flag_en[1]  = rd_stat_en;
   assign flag_clr[0] = wr_rdy_clr;
   assign flag_clr[1] = rd_rdy_clr;

   // R9 / R10: one sticky flag per direction
   for (genvar d = 0; d < NUM_DIRS; d++) begin : g_flag
      logic seen;
      assign seen = req_w & (dir_rd == xfer_dir_e'(d));
      wm_stat_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_seen (seen),
         .stat_en  (flag_en[d]),
         .clr      (flag_clr[d]),
         .flag     (flag_out[d])
      );
   end

   assign dma_req = req_w;
   assign wr_rdy  = flag_out[0];
   assign rd_rdy  = flag_out[1];

endmodule

// File: tb/wm_dma_req_tb.sv
module wm_dma_req_tb;

   localparam int unsigned DEPTH  = 16;
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
   localparam time         CLK_PD = 10ns;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ext_req_en, int_dma_on, dir_rd;
   logic [CNT_W-1:0] level, capacity, wr_wm, rd_wm;
   logic             wr_stat_en, rd_stat_en, port_acc, wr_rdy_clr, rd_rdy_clr;
   logic             dma_req, wr_rdy, rd_rdy;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PD / 2) clk = ~clk;

   wm_dma_req #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_req_en(ext_req_en), .int_dma_on(int_dma_on),
      .dir_rd(dir_rd), .level(level), .capacity(capacity), .wr_wm(wr_wm),
      .rd_wm(rd_wm), .wr_stat_en(wr_stat_en), .rd_stat_en(rd_stat_en),
      .port_acc(port_acc), .wr_rdy_clr(wr_rdy_clr), .rd_rdy_clr(rd_rdy_clr),
      .dma_req(dma_req), .wr_rdy(wr_rdy), .rd_rdy(rd_rdy)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one rising edge, then back to the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset();
      check("R5 reset dma_req", dma_req, 1'b0);
      check("R9 reset wr_rdy", wr_rdy, 1'b0);
      check("R10 reset rd_rdy", rd_rdy, 1'b0);
   endtask

   task automatic t_write_thresh();
      dir_rd = 1'b0; capacity = 5'd16; wr_wm = 5'd4; level = 5'd10;
      tick(); check("R2 free 6 >= 4", dma_req, 1'b1);
      level = 5'd13;
      tick(); check("R2 free 3 < 4", dma_req, 1'b0);
      level = 5'd12;
      tick(); check("R2 free 4 == 4", dma_req, 1'b1);
      level = 5'd16; capacity = 5'd10;
      tick(); check("R2 level above capacity", dma_req, 1'b0);
      capacity = 5'd16;
   endtask

   task automatic t_read_thresh();
      rd_wm = 5'd8; level = 5'd8; dir_rd = 1'b1;
      tick(); check("R8 dir change gap", dma_req, 1'b0);
      tick(); check("R3 level 8 >= 8", dma_req, 1'b1);
      level = 5'd7;
      tick(); check("R3 level 7 < 8", dma_req, 1'b0);
      level = 5'd8;
      tick(); check("R5 reasserts after edge", dma_req, 1'b1);
   endtask

   task automatic t_access_pacing();
      port_acc = 1'b1; settle();
      check("R6 drop in access cycle", dma_req, 1'b0);
      tick(); port_acc = 1'b0; settle();
      check("R7 low after access", dma_req, 1'b0);
      tick(); check("R7 returns", dma_req, 1'b1);
      port_acc = 1'b1; level = 5'd2;
      tick(); port_acc = 1'b0;
      tick(); check("R7 no return when condition fails", dma_req, 1'b0);
      level = 5'd8;
      tick(); check("R7 condition back", dma_req, 1'b1);
   endtask

   task automatic t_gating();
      int_dma_on = 1'b1;
      tick(); check("R1 internal dma blocks", dma_req, 1'b0);
      int_dma_on = 1'b0; ext_req_en = 1'b0;
      tick(); check("R1 ext disable blocks", dma_req, 1'b0);
      ext_req_en = 1'b1;
      tick(); check("R1 re-enabled", dma_req, 1'b1);
   endtask

   task automatic t_wm_clamp();
      rd_wm = 5'd0; level = 5'd0;
      tick(); check("R4 wm 0 level 0", dma_req, 1'b0);
      level = 5'd1;
      tick(); check("R4 wm 0 acts as 1", dma_req, 1'b1);
      rd_wm = 5'd31; level = 5'd15;
      tick(); check("R4 wm 31 level 15", dma_req, 1'b0);
      level = 5'd16;
      tick(); check("R4 wm 31 acts as DEPTH", dma_req, 1'b1);
      dir_rd = 1'b0; wr_wm = 5'd0; level = 5'd16;
      tick(); tick(); check("R4 write wm 0 free 0", dma_req, 1'b0);
      level = 5'd15;
      tick(); check("R4 write wm 0 free 1", dma_req, 1'b1);
   endtask

   task automatic t_flags();
      // write request is high here; status enable off
      tick(); check("R9 no set when disabled", wr_rdy, 1'b0);
      wr_stat_en = 1'b1;
      tick(); check("R9 set after request", wr_rdy, 1'b1);
      check("R10 untouched by write", rd_rdy, 1'b0);
      wr_stat_en = 1'b0; level = 5'd16;
      tick(); tick(); check("R9 sticky after request drop", wr_rdy, 1'b1);
      wr_rdy_clr = 1'b1;
      tick(); wr_rdy_clr = 1'b0;
      check("R11 clear wr_rdy", wr_rdy, 1'b0);
      rd_wm = 5'd4; dir_rd = 1'b1; rd_stat_en = 1'b1;
      tick(); tick(); check("R10 request seen", dma_req, 1'b1);
      rd_rdy_clr = 1'b1;
      tick(); check("R11 set wins over clear", rd_rdy, 1'b1);
      rd_rdy_clr = 1'b0; rd_stat_en = 1'b0;
      check("R9 no set during read", wr_rdy, 1'b0);
      rd_rdy_clr = 1'b1;
      tick(); rd_rdy_clr = 1'b0;
      check("R11 clear rd_rdy", rd_rdy, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; ext_req_en = 1'b1; int_dma_on = 1'b0; dir_rd = 1'b0;
      level = '0; capacity = 5'd16; wr_wm = 5'd4; rd_wm = 5'd4;
      wr_stat_en = 1'b0; rd_stat_en = 1'b0; port_acc = 1'b0;
      wr_rdy_clr = 1'b0; rd_rdy_clr = 1'b0;
      level = 5'd16;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_write_thresh();
      t_read_thresh();
      t_access_pacing();
      t_gating();
      t_wm_clamp();
      t_flags();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PD * 5000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule